// File: doc/BRIEF.md
# Mapped Control/Status Register Block

This block sits behind a simple register port (write enable with address and data, plus a read request answered by a read-valid strobe) and gives a storage-controller host its programming model. The upper address bits select one of six areas: a write-only control area, a read-only status area, a write-only area for the sixteen dwords of a command entry, a read-only area for the four dwords of a completion, and two 8 KB RAM windows. The RAM windows are read-only here, and their contents sit outside the block.

The control area holds a 48-bit start address, a 48-bit length, a pattern selector, a timeout value and a 3-bit command field. Writing a defined code into the command field launches the command: the block raises a one-cycle request next to the new code. Reads go through a two-level registered multiplexer. The first level picks a word inside an area, or lets the RAM read its word. The second level picks the area. Every read therefore answers exactly two cycles after its request, and requests may arrive back to back.

Top module: `csr_block`

## Requirements
- R1: Control words sit at these byte offsets. 0x00 holds start address bits [31:0] and 0x04 bits [15:0] give start address bits [47:32]. 0x08 and 0x0C give the length in the same way. Bits [2:0] at 0x14 give the pattern selector and 0x20 gives the timeout. Each write stores the full word, or the listed bits of it, whatever the byte enables are.
- R2: Read-valid rises exactly two clock cycles after the cycle that carries the read request, with the read data, once per request, including back-to-back requests.
- R3: A write to byte offset 0x10 with a defined code in bits [2:0] (000 identify, 001 shutdown, 010 write, 011 read, 100 custom, 110 flush) updates the command output and pulses the command request for exactly one cycle, in the cycle after the write.
- R4: A write to offset 0x10 with a reserved code (101 or 111) raises no request and leaves the command output unchanged.
- R5: A write to 0x200 + 4*i (i = 0..15) drives command-entry dword i on bits [32*i+31:32*i] of the entry output. Writes to 0x240–0x2FF change nothing.
- R6: A read of 0x100 returns busy in bit 0, error in bit 1, verification-fail in bit 2 and zero above. A read of 0x104 returns the error-detail word. Every other status offset reads zero.
- R7: A read of 0x300 + 4*j (j = 0..3) returns completion dword j. Every other offset in 0x300–0x3FF reads zero.
- R8: A read in 0x2000–0x3FFF returns the identify RAM word at index addr[12:2], and a read in 0x4000–0x5FFF returns the custom RAM word at that index. The RAM address outputs carry addr[12:2] during the request cycle, and the RAM answers one cycle later.
- R9: A read of a write-only area (0x000–0x0FF, 0x200–0x2FF) or of an unmapped address returns zero and still produces read-valid.
- R10: A write to a read-only area, to a RAM window or to an unmapped address leaves every control and command-entry output unchanged and raises no command request.
- R11: After reset all control and command-entry outputs are zero and no request or read-valid is raised, except the timeout, which holds the TIMEOUT_RST parameter (default 0x0080_0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 16 | Byte address, shared by reads and writes |
| reg_wr_en_i | input | 1 | Write strobe |
| reg_wr_data_i | input | 32 | Write data |
| reg_wr_be_i | input | 4 | Byte enables (not used) |
| reg_rd_req_i | input | 1 | Read request |
| reg_rd_data_o | output | 32 | Read data |
| reg_rd_valid_o | output | 1 | Read data valid |
| start_addr_o | output | 48 | Start address |
| xfer_len_o | output | 48 | Transfer length |
| cmd_o | output | 3 | Command code |
| cmd_req_o | output | 1 | One-cycle command request |
| patt_sel_o | output | 3 | Pattern selector |
| timeout_o | output | 32 | Timeout value |
| sq_dw_o | output | 512 | Command-entry dwords, dword i on [32i+31:32i] |
| busy_i | input | 1 | Controller busy |
| error_i | input | 1 | Controller error |
| verify_fail_i | input | 1 | Data verification failed |
| err_type_i | input | 32 | Error detail |
| cq_dw_i | input | 128 | Completion dwords, dword j on [32j+31:32j] |
| iden_addr_o | output | 11 | Identify RAM word index |
| iden_data_i | input | 32 | Identify RAM read data, one cycle after the address |
| ctm_addr_o | output | 11 | Custom RAM word index |
| ctm_data_i | input | 32 | Custom RAM read data, one cycle after the address |

## Verification
All eight command codes go through the command field, which separates launching codes from reserved ones, and the words written around it show that nothing else pulses. All eight busy/error/verify combinations and every word offset of the status, completion and write-only areas are read, which tells word selection apart from area selection. Both RAM windows are read at spread-out indices and at their first and last words, with address-derived contents, so an index or window swap shows up. Back-to-back reads to different areas, and writes aimed at each read-only region, show that the read pipeline and the write decode are independent.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int WA_W   = ADDR_W - 2;   // dword address width
  localparam int RAM_AW = 11;           // 8 KB window in dwords

  typedef enum logic [2:0] {
    AR_NONE, AR_CTRL, AR_STAT, AR_SQ, AR_CQ, AR_IDEN, AR_CTM
  } area_e;

  // dword offsets inside control area
  localparam logic [5:0] W_ADDR_LO = 6'h00;
  localparam logic [5:0] W_ADDR_HI = 6'h01;
  localparam logic [5:0] W_LEN_LO  = 6'h02;
  localparam logic [5:0] W_LEN_HI  = 6'h03;
  localparam logic [5:0] W_CMD     = 6'h04;
  localparam logic [5:0] W_PATT    = 6'h05;
  localparam logic [5:0] W_TMO     = 6'h08;
  // dword offsets inside status area
  localparam logic [5:0] W_STATUS  = 6'h00;
  localparam logic [5:0] W_ERRTYPE = 6'h01;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
(
  input  logic [WA_W-1:0]   waddr_i,
  output area_e             area_o,
  output logic [5:0]        word_o,
  output logic [RAM_AW-1:0] ram_idx_o
);
  always_comb begin
    word_o    = waddr_i[5:0];
    ram_idx_o = waddr_i[RAM_AW-1:0];
    area_o    = AR_NONE;
    if (waddr_i[WA_W-1:8] == '0) begin
      case (waddr_i[7:6])
        2'd0:    area_o = AR_CTRL;
        2'd1:    area_o = AR_STAT;
        2'd2:    area_o = AR_SQ;
        default: area_o = AR_CQ;
      endcase
    end else if (waddr_i[WA_W-1:RAM_AW] == 3'b001) begin
      area_o = AR_IDEN;
    end else if (waddr_i[WA_W-1:RAM_AW] == 3'b010) begin
      area_o = AR_CTM;
    end
  end
endmodule

// File: rtl/csr_ctrl_regs.sv
module csr_ctrl_regs
  import csr_pkg::*;
#(
  parameter int          SQ_WORDS    = 16,
  parameter logic [31:0] TIMEOUT_RST = 32'h0080_0000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_ctrl_i,
  input  logic                         wr_sq_i,
  input  logic [5:0]                   word_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [47:0]                  start_addr_o,
  output logic [47:0]                  xfer_len_o,
  output logic [2:0]                   cmd_o,
  output logic                         cmd_req_o,
  output logic [2:0]                   patt_sel_o,
  output logic [DATA_W-1:0]            timeout_o,
  output logic [SQ_WORDS*DATA_W-1:0]   sq_dw_o
);
  logic [DATA_W-1:0] sq_q [SQ_WORDS];
  logic              code_ok;

  // 101 and 111 are reserved
  assign code_ok = !(wdata_i[2] && wdata_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_addr_o <= '0;
      xfer_len_o   <= '0;
      cmd_o        <= '0;
      cmd_req_o    <= 1'b0;
      patt_sel_o   <= '0;
      timeout_o    <= TIMEOUT_RST;
    end else begin
      cmd_req_o <= 1'b0;
      if (wr_ctrl_i) begin
        case (word_i)
          W_ADDR_LO: start_addr_o[31:0]  <= wdata_i;
          W_ADDR_HI: start_addr_o[47:32] <= wdata_i[15:0];
          W_LEN_LO:  xfer_len_o[31:0]    <= wdata_i;
          W_LEN_HI:  xfer_len_o[47:32]   <= wdata_i[15:0];
          W_CMD: if (code_ok) begin
            cmd_o     <= wdata_i[2:0];
            cmd_req_o <= 1'b1;
          end
          W_PATT:    patt_sel_o <= wdata_i[2:0];
          W_TMO:     timeout_o  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SQ_WORDS; i++) sq_q[i] <= '0;
    end else if (wr_sq_i) begin
      for (int i = 0; i < SQ_WORDS; i++)
        if (word_i == 6'(i)) sq_q[i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < SQ_WORDS; g++) begin : g_sq_out
    assign sq_dw_o[g*DATA_W +: DATA_W] = sq_q[g];
  end
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
  import csr_pkg::*;
#(
  parameter int CQ_WORDS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_req_i,
  input  area_e                      area_i,
  input  logic [5:0]                 word_i,
  input  logic                       busy_i,
  input  logic                       error_i,
  input  logic                       verify_fail_i,
  input  logic [DATA_W-1:0]          err_type_i,
  input  logic [CQ_WORDS*DATA_W-1:0] cq_dw_i,
  input  logic [DATA_W-1:0]          iden_data_i,
  input  logic [DATA_W-1:0]          ctm_data_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic                       rd_valid_o
);
  localparam int CQ_IW = $clog2(CQ_WORDS);

  logic [DATA_W-1:0] l1_d, l1_q;
  area_e             area_q;
  logic              v1_q;

  // level 1: word inside the register areas
  always_comb begin
    l1_d = '0;
    case (area_i)
      AR_STAT: begin
        if (word_i == W_STATUS)
          l1_d = {{(DATA_W-3){1'b0}}, verify_fail_i, error_i, busy_i};
        else if (word_i == W_ERRTYPE)
          l1_d = err_type_i;
      end
      AR_CQ: begin
        if ({1'b0, word_i} < 7'(CQ_WORDS))
          l1_d = cq_dw_i[word_i[CQ_IW-1:0]*DATA_W +: DATA_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_q   <= '0;
      area_q <= AR_NONE;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= rd_req_i;
      if (rd_req_i) begin
        l1_q   <= l1_d;
        area_q <= area_i;
      end
    end
  end

  // level 2: area select, RAM data arrives here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= v1_q;
      if (v1_q) begin
        case (area_q)
          AR_IDEN: rd_data_o <= iden_data_i;
          AR_CTM:  rd_data_o <= ctm_data_i;
          default: rd_data_o <= l1_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/csr_block.sv
module csr_block
  import csr_pkg::*;
#(
  parameter int          SQ_WORDS    = 16,
  parameter int          CQ_WORDS    = 4,
  parameter logic [31:0] TIMEOUT_RST = 32'h0080_0000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic                       reg_wr_en_i,
  input  logic [DATA_W-1:0]          reg_wr_data_i,
  input  logic [3:0]                 reg_wr_be_i,
  input  logic                       reg_rd_req_i,
  output logic [DATA_W-1:0]          reg_rd_data_o,
  output logic                       reg_rd_valid_o,
  output logic [47:0]                start_addr_o,
  output logic [47:0]                xfer_len_o,
  output logic [2:0]                 cmd_o,
  output logic                       cmd_req_o,
  output logic [2:0]                 patt_sel_o,
  output logic [DATA_W-1:0]          timeout_o,
  output logic [SQ_WORDS*DATA_W-1:0] sq_dw_o,
  input  logic                       busy_i,
  input  logic                       error_i,
  input  logic                       verify_fail_i,
  input  logic [DATA_W-1:0]          err_type_i,
  input  logic [CQ_WORDS*DATA_W-1:0] cq_dw_i,
  output logic [RAM_AW-1:0]          iden_addr_o,
  input  logic [DATA_W-1:0]          iden_data_i,
  output logic [RAM_AW-1:0]          ctm_addr_o,
  input  logic [DATA_W-1:0]          ctm_data_i
);
  area_e             area;
  logic [5:0]        word;
  logic [RAM_AW-1:0] ram_idx;
  logic              unused_in_bits;

  // full-word writes only: byte enables and byte offset are don't-care
  assign unused_in_bits = ^{reg_addr_i[1:0], reg_wr_be_i};

  csr_decode u_dec (
    .waddr_i   (reg_addr_i[ADDR_W-1:2]),
    .area_o    (area),
    .word_o    (word),
    .ram_idx_o (ram_idx)
  );

  csr_ctrl_regs #(
    .SQ_WORDS    (SQ_WORDS),
    .TIMEOUT_RST (TIMEOUT_RST)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ctrl_i    (reg_wr_en_i && area == AR_CTRL),
    .wr_sq_i      (reg_wr_en_i && area == AR_SQ),
    .word_i       (word),
    .wdata_i      (reg_wr_data_i),
    .start_addr_o (start_addr_o),
    .xfer_len_o   (xfer_len_o),
    .cmd_o        (cmd_o),
    .cmd_req_o    (cmd_req_o),
    .patt_sel_o   (patt_sel_o),
    .timeout_o    (timeout_o),
    .sq_dw_o      (sq_dw_o)
  );

  assign iden_addr_o = ram_idx;
  assign ctm_addr_o  = ram_idx;

  csr_read_mux #(
    .CQ_WORDS (CQ_WORDS)
  ) u_rmux (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_req_i      (reg_rd_req_i),
    .area_i        (area),
    .word_i        (word),
    .busy_i        (busy_i),
    .error_i       (error_i),
    .verify_fail_i (verify_fail_i),
    .err_type_i    (err_type_i),
    .cq_dw_i       (cq_dw_i),
    .iden_data_i   (iden_data_i),
    .ctm_data_i    (ctm_data_i),
    .rd_data_o     (reg_rd_data_o),
    .rd_valid_o    (reg_rd_valid_o)
  );
endmodule

// File: rtl/csr_block_chk.sv
module csr_block_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] reg_addr_i,
  input logic        reg_wr_en_i,
  input logic [31:0] reg_wr_data_i,
  input logic        reg_rd_req_i,
  input logic        reg_rd_valid_o,
  input logic [47:0] start_addr_o,
  input logic [2:0]  cmd_o,
  input logic        cmd_req_o,
  input logic [31:0] timeout_o
);
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_req_i |=> ##1 reg_rd_valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_valid_o |-> $past(reg_rd_req_i, 2)); // R2
  AST_CMD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |-> $past(reg_wr_en_i && reg_addr_i[15:2] == 14'h0004
                        && !(reg_wr_data_i[2] && reg_wr_data_i[0]))); // R3
  AST_CMD_NOT_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |-> !(cmd_o[2] && cmd_o[0])); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_wr_en_i) |-> $stable(cmd_o) && $stable(timeout_o) && !cmd_req_o); // R3
  AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_wr_en_i && reg_addr_i[15:8] != 8'h00 && reg_addr_i[15:8] != 8'h02)
    |-> $stable(start_addr_o) && $stable(cmd_o) && $stable(timeout_o) && !cmd_req_o); // R10
endmodule

bind csr_block csr_block_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_addr_i     (reg_addr_i),
  .reg_wr_en_i    (reg_wr_en_i),
  .reg_wr_data_i  (reg_wr_data_i),
  .reg_rd_req_i   (reg_rd_req_i),
  .reg_rd_valid_o (reg_rd_valid_o),
  .start_addr_o   (start_addr_o),
  .cmd_o          (cmd_o),
  .cmd_req_o      (cmd_req_o),
  .timeout_o      (timeout_o)
);

// File: tb/tb_csr_block.sv
module tb_csr_block;
  localparam int SQW = 16;
  localparam int CQW = 4;
  localparam logic [31:0] TMO_RST = 32'h0080_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       addr = '0;
  logic              wr_en = 1'b0;
  logic [31:0]       wdata = '0;
  logic [3:0]        be = 4'hF;
  logic              rd_req = 1'b0;
  logic [31:0]       rdata;
  logic              rvalid;
  logic [47:0]       start_addr, xfer_len;
  logic [2:0]        cmd, patt;
  logic              cmd_req;
  logic [31:0]       tmo;
  logic [SQW*32-1:0] sq;
  logic              busy = 1'b0, err = 1'b0, vfail = 1'b0;
  logic [31:0]       err_type = 32'hE000_0042;
  logic [CQW*32-1:0] cq;
  logic [10:0]       iden_addr, ctm_addr;
  logic [31:0]       iden_q = '0, ctm_q = '0;

  int checks = 0;
  int errors = 0;

  // bench-side expected control state
  logic [47:0] e_addr = '0, e_len = '0;
  logic [2:0]  e_cmd = '0, e_patt = '0;
  logic [31:0] e_tmo = TMO_RST;
  logic [31:0] e_sq [SQW];

  always #4 clk = ~clk;

  function automatic logic [31:0] iden_f(input int idx);
    return 32'h1DE0_0000 | 32'(idx);
  endfunction
  function automatic logic [31:0] ctm_f(input int idx);
    return 32'hC7A0_0000 | 32'(idx * 3);
  endfunction
  function automatic logic [31:0] cq_f(input int j);
    return 32'hC900_0000 | 32'(j * 32'h111);
  endfunction

  for (genvar j = 0; j < CQW; j++) begin : g_cq
    assign cq[j*32 +: 32] = cq_f(j);
  end

  // 1-cycle-latency RAM models
  always @(posedge clk) begin
    iden_q <= iden_f(int'(iden_addr));
    ctm_q  <= ctm_f(int'(ctm_addr));
  end

  csr_block #(.SQ_WORDS(SQW), .CQ_WORDS(CQW), .TIMEOUT_RST(TMO_RST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_en_i(wr_en),
    .reg_wr_data_i(wdata), .reg_wr_be_i(be), .reg_rd_req_i(rd_req),
    .reg_rd_data_o(rdata), .reg_rd_valid_o(rvalid), .start_addr_o(start_addr),
    .xfer_len_o(xfer_len), .cmd_o(cmd), .cmd_req_o(cmd_req), .patt_sel_o(patt),
    .timeout_o(tmo), .sq_dw_o(sq), .busy_i(busy), .error_i(err),
    .verify_fail_i(vfail), .err_type_i(err_type), .cq_dw_i(cq),
    .iden_addr_o(iden_addr), .iden_data_i(iden_q), .ctm_addr_o(ctm_addr),
    .ctm_data_i(ctm_q)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_ctrl(input string tag);
    check({tag, " start_addr"}, 64'(start_addr), 64'(e_addr));
    check({tag, " xfer_len"}, 64'(xfer_len), 64'(e_len));
    check({tag, " cmd"}, 64'(cmd), 64'(e_cmd));
    check({tag, " patt"}, 64'(patt), 64'(e_patt));
    check({tag, " timeout"}, 64'(tmo), 64'(e_tmo));
    for (int i = 0; i < SQW; i++)
      check({tag, " sq dword"}, 64'(sq[i*32 +: 32]), 64'(e_sq[i]));
  endtask

  // outputs reflect the write when this returns
  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    addr = a; wdata = d; be = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; be = 4'hF;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check({tag, " R2 valid early"}, 64'(rvalid), 64'd0);
    @(negedge clk);
    check({tag, " R2 valid"}, 64'(rvalid), 64'd1);
    check({tag, " data"}, 64'(rdata), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < SQW; i++) e_sq[i] = '0;
    repeat (3) @(negedge clk);
    check_ctrl("R11 reset");
    check("R11 cmd_req reset", 64'(cmd_req), 64'd0);
    check("R11 valid reset", 64'(rvalid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_ctrl("R11 after release");

    // R1 control words
    wr(16'h0000, 32'h89AB_CDEF); e_addr[31:0] = 32'h89AB_CDEF;
    wr(16'h0004, 32'hFFFF_1234); e_addr[47:32] = 16'h1234;
    wr(16'h0008, 32'h0000_0400); e_len[31:0] = 32'h0000_0400;
    wr(16'h000C, 32'hABCD_0002); e_len[47:32] = 16'h0002;
    wr(16'h0014, 32'hFFFF_FFFC); e_patt = 3'b100;
    wr(16'h0020, 32'h1234_5678, 4'b0001); e_tmo = 32'h1234_5678;
    check_ctrl("R1 control");
    wr(16'h0020, 32'h0000_0000, 4'b0000); e_tmo = 32'h0;
    check("R1 timeout no-byte-enable", 64'(tmo), 64'(e_tmo));

    // R3/R4 every command code, upper bits junk
    for (int c = 0; c < 8; c++) begin
      bit rsvd;
      rsvd = (c == 5) || (c == 7);
      wr(16'h0010, {29'h1555_5555, 3'(c)});
      if (!rsvd) e_cmd = 3'(c);
      if (rsvd) begin
        check("R4 reserved no request", 64'(cmd_req), 64'd0);
        check("R4 reserved cmd kept", 64'(cmd), 64'(e_cmd));
      end else begin
        check("R3 request pulse", 64'(cmd_req), 64'd1);
        check("R3 cmd code", 64'(cmd), 64'(e_cmd));
      end
      @(negedge clk);
      check("R3 pulse one cycle", 64'(cmd_req), 64'd0);
    end
    wr(16'h0018, 32'hFFFF_FFFF);
    check("R3 other offset no request", 64'(cmd_req), 64'd0);
    check_ctrl("R3 after sweep");

    // R5 command-entry array
    for (int i = 0; i < SQW; i++) begin
      e_sq[i] = 32'h0F0F_0000 ^ (32'(i) * 32'h1111_1111);
      wr(16'(16'h0200 + 4 * i), e_sq[i]);
    end
    check_ctrl("R5 entry");
    wr(16'h0240, 32'hDEAD_BEEF);
    wr(16'h02FC, 32'hDEAD_BEEF);
    check_ctrl("R5 beyond array");

    // R6 status
    for (int s = 0; s < 8; s++) begin
      busy = s[0]; err = s[1]; vfail = s[2];
      rd(16'h0100, 32'(s), "R6 status bits");
    end
    rd(16'h0104, 32'hE000_0042, "R6 error detail");
    for (int o = 16'h108; o < 16'h200; o += 4)
      rd(16'(o), 32'h0, "R6 empty status");

    // R7 completion
    for (int o = 0; o < 256; o += 4)
      rd(16'(16'h0300 + o), (o / 4 < CQW) ? cq_f(o / 4) : 32'h0, "R7 completion");

    // R9 write-only and unmapped reads
    for (int o = 0; o < 256; o += 4) begin
      rd(16'(o), 32'h0, "R9 control readback");
      rd(16'(16'h0200 + o), 32'h0, "R9 entry readback");
    end
    rd(16'h0400, 32'h0, "R9 unmapped");
    rd(16'h1FFC, 32'h0, "R9 unmapped");
    rd(16'h6000, 32'h0, "R9 unmapped");
    rd(16'hFFFC, 32'h0, "R9 unmapped");

    // R8 RAM windows
    for (int k = 0; k < 2048; k += 97) begin
      rd(16'(16'h2000 + 4 * k), iden_f(k), "R8 identify");
      rd(16'(16'h4000 + 4 * k), ctm_f(k), "R8 custom");
    end
    rd(16'h3FFC, iden_f(2047), "R8 identify last");
    rd(16'h5FFC, ctm_f(2047), "R8 custom last");
    rd(16'h2007, iden_f(1), "R8 byte offset");

    // R2 back-to-back reads across areas
    @(negedge clk);
    addr = 16'h0104; rd_req = 1'b1;
    @(negedge clk);
    addr = 16'h2010;
    @(negedge clk);
    addr = 16'h0304;
    check("R2 b2b first valid", 64'(rvalid), 64'd1);
    check("R2 b2b first data", 64'(rdata), 64'h0000_0000_E000_0042);
    @(negedge clk);
    rd_req = 1'b0;
    check("R2 b2b second valid", 64'(rvalid), 64'd1);
    check("R2 b2b second data", 64'(rdata), 64'(iden_f(4)));
    @(negedge clk);
    check("R2 b2b third valid", 64'(rvalid), 64'd1);
    check("R2 b2b third data", 64'(rdata), 64'(cq_f(1)));
    @(negedge clk);
    check("R2 b2b idle", 64'(rvalid), 64'd0);

    // R10 writes outside writable areas
    wr(16'h0100, 32'hFFFF_FFFF); check("R10 no request", 64'(cmd_req), 64'd0);
    wr(16'h0104, 32'hFFFF_FFFF);
    wr(16'h0310, 32'hFFFF_FFFF); check("R10 no request", 64'(cmd_req), 64'd0);
    wr(16'h2010, 32'hFFFF_FFFF);
    wr(16'h4010, 32'hFFFF_FFFF);
    wr(16'h0810, 32'hFFFF_FFFF); check("R10 no request", 64'(cmd_req), 64'd0);
    wr(16'hFFF0, 32'hFFFF_FFFF);
    check_ctrl("R10 read-only writes");
    rd(16'h4010, ctm_f(4), "R10 custom RAM after write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule